// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Request Latch

The block turns eight interrupt request lines into a pending-request vector. Each line has its own trigger-mode bit. In edge mode a rising transition is captured and held until an interrupt controller acknowledges it. In level mode the pending bit simply tracks the line, so several open-collector style sources can share one line and keep it pending until the last of them lets go.

The trigger-mode bits sit in one register on a small register bus with a single write strobe and a combinational read path. Two copies of the block are meant to be used side by side on one bus: each copy answers only at its own address (the lower address for the first, the next one for the second). Request inputs are synchronised with two flip-flops before they are used, so they may come from any clock domain. Priority, masking and vectoring belong to the controller that consumes the pending vector.

Top module: `irq_trigger_latch`

## Requirements
- R1: In edge mode (mode bit 0), a rising transition on `irq_line[n]` driven between clock edges makes `pending[n]` high after the third following rising clock edge, and not before.
- R2: In edge mode, `pending[n]` stays high after `irq_line[n]` falls, for as long as `irq_ack[n]` stays low.
- R3: In edge mode, a pending line whose `irq_ack[n]` is high at a rising clock edge shows `pending[n]` low after that edge.
- R4: In edge mode, after an acknowledge a line that stays high never sets `pending[n]` again; a new request is taken only after the synchronised line has been low for at least one cycle.
- R5: In level mode (mode bit 1), `pending[n]` equals `irq_line[n]` delayed by two clock edges, `irq_ack[n]` has no effect, and a line kept high by any of several sharing sources stays pending until all have released it.
- R6: Trigger-mode bit n controls line n only: bit n = 1 selects level mode and bit n = 0 selects edge mode, and lines with different modes work side by side.
- R7: A write with `reg_wr` high at a clock edge loads `reg_wdata` into the mode register only when `reg_addr` equals the instance address `INST_ADDR`; `reg_rdata` returns the mode register at once when addressed and zero otherwise.
- R8: Synchronous active-high reset clears the mode register (all lines edge mode) and all pending bits.
- R9: A write that changes a line's mode bit discards that line's captured edge request, and an edge-mode line that is high at that moment must go low before it can request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_line | input | LINES | Asynchronous interrupt request lines |
| irq_ack | input | LINES | Per-line acknowledge from the controller |
| reg_addr | input | ADDR_W | Register address shared by paired instances |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | LINES | Trigger-mode write data, bit n for line n |
| reg_rdata | output | LINES | Mode register when addressed, otherwise zero |
| pending | output | LINES | Pending request per line |

## Verification
A request driven between edges is due after two rising edges in level mode and after three in edge mode, because of the two synchroniser stages and the edge latch; the bench samples one negative edge before each deadline to see it still low, then on the deadline. Acknowledges and mode writes act on the very next edge, so their results are sampled at the following negative edge, and read data is sampled in the same half cycle the address is set. Holding checks wait several cycles past each deadline so that a late change would also be caught.

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch #(
  parameter int LINES = 8,
  parameter int ADDR_W = 1,
  parameter int unsigned INST_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_line,
  input  logic [LINES-1:0]  irq_ack,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic [LINES-1:0]  pending
);

  logic [LINES-1:0] mode, sync_a, sync_b, held, blocked;

  wire sel    = (reg_addr == ADDR_W'(INST_ADDR));
  wire wr_hit = reg_wr & sel;
  wire [LINES-1:0] mode_chg = wr_hit ? (reg_wdata ^ mode) : '0;
  wire [LINES-1:0] take     = sync_b & ~blocked & ~held;

  assign pending   = (mode & sync_b) | (~mode & held);
  assign reg_rdata = sel ? mode : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      sync_a  <= '0;
      sync_b  <= '0;
      held    <= '0;
      blocked <= '0;
    end else begin
      sync_a <= irq_line;
      sync_b <= sync_a;
      if (wr_hit) mode <= reg_wdata;
      held    <= ~mode & ~mode_chg & ((held & ~irq_ack) | take);
      blocked <= mode | mode_chg | take | (blocked & (held | sync_b));
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && pending == '0));

  assert_write_loads_R7: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mode == $past(reg_wdata));

  for (genvar n = 0; n < LINES; n++) begin : g_chk
    assert_edge_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!mode[n] && pending[n] && !irq_ack[n] && !mode_chg[n]) |=> pending[n]);

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (!mode[n] && pending[n] && irq_ack[n] && !mode_chg[n]) |=> !pending[n]);

    assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode[n] && !pending[n] && sync_b[n] && $past(sync_b[n]) && !mode_chg[n])
        |=> !pending[n]);

    assert_level_follows_R5: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && mode[n]) |-> pending[n] == $past(irq_line[n], 2));

    assert_mode_change_drops_R9: assert property (@(posedge clk) disable iff (rst)
      (mode_chg[n] && reg_wdata[n] == 1'b0) |=> !pending[n]);
  end

endmodule

// File: tb/irq_trigger_latch_test.sv
module irq_trigger_latch_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [15:0] src_a, src_b, ack, pend;
  wire  [15:0] req = src_a | src_b;
  logic [0:0]  addr;
  logic        wr;
  logic [7:0]  wdata, rdata0, rdata1;
  int total = 0, bad = 0;
  bit done = 0;

  irq_trigger_latch #(.LINES(8), .ADDR_W(1), .INST_ADDR(0)) uut (
    .clk(clk), .rst(rst), .irq_line(req[7:0]), .irq_ack(ack[7:0]),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata0), .pending(pend[7:0]));

  irq_trigger_latch #(.LINES(8), .ADDR_W(1), .INST_ADDR(1)) uut_hi (
    .clk(clk), .rst(rst), .irq_line(req[15:8]), .irq_ack(ack[15:8]),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata1), .pending(pend[15:8]));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic pulse_ack(input logic [15:0] m);
    ack = m;
    tick(1);
    ack = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; src_a = '0; src_b = '0; ack = '0; addr = '0; wr = 1'b0; wdata = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R8 pending", pend, 16'h0);
    addr = 1'b0; #1 chk("R8 mode0", {8'h0, rdata0}, 16'h0);
    addr = 1'b1; #1 chk("R8 mode1", {8'h0, rdata1}, 16'h0);
    tick(1);

    set_mode(1'b0, 8'hA5);
    set_mode(1'b1, 8'h3C);
    addr = 1'b0; #1 chk("R7 read0", {rdata1, rdata0}, 16'h00A5);
    addr = 1'b1; #1 chk("R7 read1", {rdata1, rdata0}, 16'h3C00);
    tick(1);

    src_a = 16'hFFFF;
    tick(3);
    chk("R6 all high", pend, 16'hFFFF);
    src_a = '0;
    tick(3);
    chk("R6 edge lines held", pend, ~16'h3CA5);
    pulse_ack(16'hFFFF);
    chk("R6 acked", pend, 16'h0);

    set_mode(1'b0, 8'h00);
    set_mode(1'b1, 8'h00);
    tick(3);
    for (int i = 0; i < 16; i++) begin
      src_a[i] = 1'b1;
      tick(2); chk("R1 early", pend, 16'h0);
      tick(1); chk("R1 set", pend, 16'(1) << i);
      src_a[i] = 1'b0;
      tick(4); chk("R2 hold", pend, 16'(1) << i);
      pulse_ack(16'(1) << i);
      chk("R3 ack", pend, 16'h0);
      tick(2);
    end

    for (int i = 0; i < 16; i++) begin
      src_a[i] = 1'b1;
      tick(3); chk("R4 first", pend, 16'(1) << i);
      pulse_ack(16'(1) << i);
      tick(5); chk("R4 held high", pend, 16'h0);
      src_a[i] = 1'b0;
      tick(3);
      src_a[i] = 1'b1;
      tick(3); chk("R4 rearmed", pend, 16'(1) << i);
      src_a[i] = 1'b0;
      pulse_ack(16'(1) << i);
      tick(2);
    end

    set_mode(1'b0, 8'hFF);
    set_mode(1'b1, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      src_a[i] = 1'b1;
      tick(1); chk("R5 early", pend, 16'h0);
      tick(1); chk("R5 follow", pend, 16'(1) << i);
      pulse_ack(16'(1) << i);
      chk("R5 ack ignored", pend, 16'(1) << i);
      src_b[i] = 1'b1; src_a[i] = 1'b0;
      tick(3); chk("R5 shared", pend, 16'(1) << i);
      src_b[i] = 1'b0;
      tick(2); chk("R5 released", pend, 16'h0);
    end

    set_mode(1'b0, 8'h00);
    set_mode(1'b1, 8'h00);
    tick(3);
    src_a[3] = 1'b1;
    tick(3); chk("R9 latched", pend, 16'h0008);
    src_a[3] = 1'b0;
    tick(3);
    set_mode(1'b0, 8'h08);
    chk("R9 to level", pend, 16'h0);
    set_mode(1'b0, 8'h00);
    tick(2);
    chk("R9 no stale", pend, 16'h0);
    set_mode(1'b0, 8'h08);
    src_a[3] = 1'b1;
    tick(2); chk("R9 level high", pend, 16'h0008);
    set_mode(1'b0, 8'h00);
    tick(4); chk("R9 no capture while high", pend, 16'h0);
    src_a[3] = 1'b0;
    tick(3);
    src_a[3] = 1'b1;
    tick(3); chk("R9 new edge", pend, 16'h0008);
    src_a[3] = 1'b0;
    pulse_ack(16'h0008);
    chk("R9 cleared", pend, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule